// File: doc/BRIEF.md
# Transpose Buffer and Pass Sequencer for an 8x8 Block Transform

This block sits between the two one-dimensional passes of a separable 2D block transform. It has a single memory of SIDE x SIDE words, 8x8 by default. The block turns the first pass's row-ordered results into the column order that the second pass needs, and it does this only by choosing addresses. It also runs the whole block operation. An idle controller waits for a start request. It then spends one cycle per element in a row pass and one cycle per element in a column pass, returns to idle and pulses done.

In the row pass, the word presented in cycle k is stored at raster address k. In the column pass, cycle k reads the address whose row and column index halves are swapped: 0, 8, 16, … 56, 1, 9, …. The word presented in that cycle is stored back at the same address, after the old value has been read out. Every busy cycle also reads its address, and the read word appears one cycle later. As a result, the row pass of the next block drains the coefficients that the previous column pass left behind.

The pass length is fixed, so neither data stream can be stalled. `wr_data` is sampled on every busy cycle. `rd_data` is qualified only by `rd_valid` and must be taken in the cycle it is offered. There is no ready signal.

Top module: `tbuf_seq`

## Requirements
- R1: A synchronous active-high `rst` sets `phase` to idle (code 0), and drives `done` and `rd_valid` low in the cycle after the reset edge.
- R2: When `start` is high in an idle cycle, `phase` reads row pass (code 1) in the following cycle.
- R3: The row pass lasts exactly 64 cycles. It is followed at once by the column pass (code 2), which also lasts 64 cycles, and then by idle.
- R4: In row-pass cycle k (k = 0..63), `wr_data` is stored at raster address k. Column-pass cycle k reads address {k[2:0], k[5:3]}, so the column pass outputs the row-pass words in transposed order.
- R5: `rd_valid` is high exactly in the cycles that follow a busy (row or column) cycle. `rd_data` then carries the word read in that busy cycle.
- R6: In column-pass cycle k, `wr_data` is written to the same column-order address that is read in that cycle. The read returns the value from before the write. The written values appear, in raster order, on the read stream of the next block's row pass.
- R7: `rd_col` is high when the current `rd_data` comes from a column-pass read, and low when it comes from a row-pass read.
- R8: `done` is a one-cycle pulse. It occurs in the first idle cycle after the column pass, together with the last column-pass read word.
- R9: `start` has no effect while `phase` is row or column pass. The sequence and its timing are unchanged.
- R10: Asserting `rst` in the middle of a block returns `phase` to idle in the next cycle. It abandons the block without a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Valid pixel data is arriving; begins a block when idle |
| wr_data | input | DATA_W | Word from the 1D datapath, written on every busy cycle |
| phase | output | 2 | Current phase: 0 idle, 1 row pass, 2 column pass |
| done | output | 1 | One-cycle pulse when a block completes |
| rd_valid | output | 1 | `rd_data` holds a word read in the previous cycle |
| rd_col | output | 1 | The current read word comes from the column pass |
| rd_data | output | DATA_W | Word read toward the 1D datapath |

## Verification
The bench targets these corner cases:

- **Swapped-index reads.** The column pass must read the swapped address at k = 1 and k = 8 and at the pass edges. A design that reads raster order or swaps the wrong halves hands back the untransposed matrix.
- **Read-before-write.** A design that returns the freshly written word, instead of the old one, in the shared column-pass cycle leaks the write-back into the column stream.
- **Back-to-back blocks.** A start that coincides with the done cycle must begin a new block at once, and its row pass must drain the previous column results.
- **Start while busy.** A start pulse during either pass must not restart the pass or shorten it.
- **Reset mid-block.** A reset in the middle of a block must return to idle without a done pulse. A design that kept its count would come back part-way through a pass.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ROW  = 2'd1,
    PH_COL  = 2'd2
  } phase_e;
endpackage

// File: rtl/tbuf_ctrl.sv
module tbuf_ctrl
  import tbuf_pkg::*;
#(
  parameter int SIDE_LG = 3,
  localparam int CNT_W  = 2 * SIDE_LG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  phase_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             last_elem;

  assign last_elem = &cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (start) st_q <= PH_ROW;
        end
        PH_ROW: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_elem) st_q <= PH_COL;
        end
        PH_COL: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_elem) begin
            st_q   <= PH_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = st_q;
  assign cnt_o   = cnt_q;
  assign done_o  = done_q;
endmodule

// File: rtl/tbuf_addr.sv
module tbuf_addr
  import tbuf_pkg::*;
#(
  parameter int SIDE_LG = 3,
  localparam int ADDR_W = 2 * SIDE_LG
) (
  input  phase_e            phase,
  input  logic [ADDR_W-1:0] cnt,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] swapped;

  // Column order: the low (column) index becomes the high address half.
  for (genvar i = 0; i < SIDE_LG; i++) begin : g_swap
    assign swapped[i + SIDE_LG] = cnt[i];
    assign swapped[i]           = cnt[i + SIDE_LG];
  end

  assign addr = (phase == PH_COL) ? swapped : cnt;
endmodule

// File: rtl/tbuf_mem.sv
module tbuf_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  // Read-first: the read returns the word held before this cycle's write.
  always_ff @(posedge clk) begin
    if (en) begin
      rdata       <= store[addr];
      store[addr] <= wdata;
    end
  end
endmodule

// File: rtl/tbuf_seq.sv
module tbuf_seq
  import tbuf_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SIDE_LG = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] wr_data,
  output logic [1:0]        phase,
  output logic              done,
  output logic              rd_valid,
  output logic              rd_col,
  output logic [DATA_W-1:0] rd_data
);
  localparam int ADDR_W = 2 * SIDE_LG;

  phase_e            cur_phase;
  logic [ADDR_W-1:0] elem_cnt;
  logic [ADDR_W-1:0] mem_addr;
  logic              busy;
  logic              rv_q;
  logic              rc_q;

  tbuf_ctrl #(.SIDE_LG(SIDE_LG)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .phase_o (cur_phase),
    .cnt_o   (elem_cnt),
    .done_o  (done)
  );

  tbuf_addr #(.SIDE_LG(SIDE_LG)) u_addr (
    .phase (cur_phase),
    .cnt   (elem_cnt),
    .addr  (mem_addr)
  );

  assign busy = (cur_phase != PH_IDLE);

  tbuf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .en    (busy && !rst),
    .addr  (mem_addr),
    .wdata (wr_data),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q <= 1'b0;
      rc_q <= 1'b0;
    end else begin
      rv_q <= busy;
      rc_q <= (cur_phase == PH_COL);
    end
  end

  assign phase    = cur_phase;
  assign rd_valid = rv_q;
  assign rd_col   = rc_q;
endmodule

// File: rtl/tbuf_seq_chk.sv
module tbuf_seq_chk #(
  parameter int SIDE_LG = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [1:0] phase,
  input logic       done,
  input logic       rd_valid,
  input logic       rd_col
);
  localparam int PASS_LEN = 1 << (2 * SIDE_LG);
  localparam int RUN_W    = 2 * SIDE_LG + 2;

  logic [RUN_W-1:0] row_run;

  always_ff @(posedge clk) begin
    if (rst || phase != 2'd1) row_run <= '0;
    else                      row_run <= row_run + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (phase == 2'd0 && !done && !rd_valid)); // R1
  AST_START_ROW: assert property (@(posedge clk) disable iff (rst) (phase == 2'd0 && start) |=> phase == 2'd1); // R2
  AST_ROW_LEN: assert property (@(posedge clk) disable iff (rst) (phase == 2'd2 && $past(phase) == 2'd1) |-> row_run == RUN_W'(PASS_LEN)); // R3
  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst) (phase != 2'd0) |=> rd_valid); // R5
  AST_COL_TAG: assert property (@(posedge clk) disable iff (rst) (phase == 2'd2) |=> rd_col); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> (phase == 2'd0 && rd_col)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst) (phase == 2'd1) |=> phase != 2'd0); // R9
endmodule

bind tbuf_seq tbuf_seq_chk #(.SIDE_LG(SIDE_LG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .phase    (phase),
  .done     (done),
  .rd_valid (rd_valid),
  .rd_col   (rd_col)
);

// File: tb/tbuf_seq_tb.sv
module tbuf_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    phase;
  logic          done, rd_valid, rd_col;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit live = 0;

  // behavioural reference
  int m_ph = 0;
  int m_k = 0;
  int m_mem [64];
  bit m_known [64];
  int e_done = 0, e_rv = 0, e_rcol = 0, e_rd = 0;
  bit e_rdk = 0;

  tbuf_seq #(.DATA_W(DW), .SIDE_LG(3)) u_dut (
    .clk(clk), .rst(rst), .start(start), .wr_data(wr_data),
    .phase(phase), .done(done), .rd_valid(rd_valid), .rd_col(rd_col),
    .rd_data(rd_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    live = 1;
    if (rst) begin
      m_ph = 0; m_k = 0; e_done = 0; e_rv = 0; e_rcol = 0;
    end else begin
      e_rv = (m_ph != 0);
      e_rcol = (m_ph == 2);
      e_done = (m_ph == 2 && m_k == 63) ? 1 : 0;
      if (m_ph != 0) begin
        int a;
        a = (m_ph == 2) ? ((m_k % 8) * 8 + m_k / 8) : m_k;
        e_rd = m_mem[a];
        e_rdk = m_known[a];
        m_mem[a] = int'(wr_data);
        m_known[a] = 1;
      end
      if (m_ph == 0) begin
        if (start) begin m_ph = 1; m_k = 0; end
      end else if (m_k == 63) begin
        m_ph = (m_ph == 1) ? 2 : 0;
        m_k = 0;
      end else m_k++;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      chk("R3", int'(phase), m_ph);
      chk("R8", int'(done), e_done);
      chk("R5", int'(rd_valid), e_rv);
      if (e_rv) begin
        chk("R7", int'(rd_col), e_rcol);
        if (e_rdk) chk(e_rcol ? "R4" : "R6", int'(rd_data), e_rd);
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_data = DW'((cyc * 37 + 11) ^ (cyc << 5));
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      wr_data = DW'((cyc * 37 + 11) ^ (cyc << 5));
      if (done) break;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin m_mem[i] = 0; m_known[i] = 0; end
    step(4);
    rst = 1'b0;
    step(1);
    chk("R1", int'(phase), 0);
    chk("R1", int'(done), 0);
    chk("R1", int'(rd_valid), 0);
    step(4);
    // block A
    start = 1'b1;
    step(1);
    start = 1'b0;
    chk("R2", int'(phase), 1);
    step(10);
    start = 1'b1;
    step(1);
    start = 1'b0;
    chk("R9", int'(phase), 1);
    step(60);
    start = 1'b1;
    step(1);
    start = 1'b0;
    chk("R9", int'(phase), 2);
    wait_done();
    // block B starts in the done cycle; drains block A
    start = 1'b1;
    step(1);
    start = 1'b0;
    chk("R2", int'(phase), 1);
    wait_done();
    step(3);
    // block C, reset part-way through its column pass
    start = 1'b1;
    step(1);
    start = 1'b0;
    step(80);
    rst = 1'b1;
    step(1);
    rst = 1'b0;
    chk("R10", int'(phase), 0);
    chk("R10", int'(done), 0);
    step(2);
    chk("R10", int'(phase), 0);
    // block D, then E drains D
    start = 1'b1;
    step(1);
    start = 1'b0;
    wait_done();
    step(2);
    start = 1'b1;
    step(1);
    start = 1'b0;
    wait_done();
    step(3);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule